// File: doc/BRIEF.md
# DMA Controller Register File and Interrupt Unit

This block is the software-visible control store of a multi-channel DMA engine. A simple 32-bit register bus writes and reads five 32-bit words per channel (source address, destination address, next-descriptor pointer, control word and channel configuration) and a small global configuration word. The transfer engine itself lives elsewhere: it consumes the stored values and reports completion or failure back to this block through one-cycle set pulses per channel.

The block keeps a raw terminal-count bit and a raw error bit for every channel. Each channel's configuration word carries its own two interrupt enables, so no separate mask register exists. Status can be read combined, masked per kind, or raw. Ones written to either clear register drop the matching raw bits. A single interrupt line is high while any enabled raw bit is set. Eight identification bytes sit at the top of the 4 KB map, one byte per word. The channel count is a parameter, 8 or 2, and the first identification byte tells the two builds apart.

Top module: `dma_regfile_irq`

## Requirements
- R1: After reset every stored register, both raw interrupt vectors and the read data output are zero, and `irq` is low.
- R2: Channel n's window starts at 0x100 + 0x20*n. Word 0x00 is the source address, 0x04 the destination, 0x08 the next-descriptor pointer, 0x0C the control word and 0x10 the configuration word. All 32 bits of each word read back as last written.
- R3: Writes to a channel window with index at or above the channel count, to words 0x14 to 0x1C of any channel window, or to an undefined global offset change nothing. Reads from any of them return zero.
- R4: A pulse on `tc_set[n]` or `err_set[n]` sets raw bit n, which reads at 0x14 (terminal count) or 0x18 (error). If a pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Writing to 0x08 clears the raw terminal-count bits where the data has ones. Writing to 0x10 does the same for the raw error bits. Data bits at or above the channel count are ignored, and both clear offsets read as zero.
- R6: Configuration bit 15 of channel n enables its terminal-count bit and bit 14 enables its error bit. The masked views read at 0x04 (terminal count) and 0x0C (error).
- R7: The combined status at 0x00 reads (raw tc AND tc enables) OR (raw err AND err enables).
- R8: `irq` is high exactly while at least one enabled raw bit, of either kind, is set.
- R9: Bit n of the read at 0x1C and of output `ch_enabled` equals configuration bit 0 of channel n.
- R10: Global configuration at 0x30 stores bits [2:0] and reads zero above them. Bit 0 drives `ctl_enable` and bits [2:1] drive `ctl_endian`.
- R11: Words 0xFE0 to 0xFFC read, in bits [7:0], 0x80 (0x81 when built with 2 channels), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05 and 0xB1. Writes there have no effect.
- R12: Read data is registered. It appears on `bus_rdata` in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tc_set | input | NCH | Terminal-count set pulses from the transfer engine |
| err_set | input | NCH | Error set pulses from the transfer engine |
| ctl_enable | output | 1 | Global configuration bit 0 |
| ctl_endian | output | 2 | Global configuration bits [2:1] |
| ch_enabled | output | NCH | Per-channel configuration bit 0 |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong raw bit shows on the 0x14 or 0x18 read one cycle after the pulse or clear that caused it. If its enable is set, it also shows on `irq` in that same cycle. A mis-decoded channel or word shows up as a read-back mismatch, or as a value appearing in the wrong window, on the very next read. The bench therefore reads every affected view straight after each stimulus. It uses a second, two-channel instance to confirm that out-of-range windows stay inert and that the identification byte changes with the channel count.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  localparam int DW = 32;

  typedef struct packed {
    logic [DW-1:0] src;
    logic [DW-1:0] dst;
    logic [DW-1:0] nxt;
    logic [DW-1:0] ctl;
    logic [DW-1:0] cfg;
  } chan_regs_t;

  // channel window word indices (addr[4:2])
  localparam logic [2:0] CW_SRC = 3'd0;
  localparam logic [2:0] CW_DST = 3'd1;
  localparam logic [2:0] CW_NXT = 3'd2;
  localparam logic [2:0] CW_CTL = 3'd3;
  localparam logic [2:0] CW_CFG = 3'd4;

  // global word indices (addr[7:2])
  localparam logic [5:0] GW_STAT   = 6'h00;
  localparam logic [5:0] GW_TCMSK  = 6'h01;
  localparam logic [5:0] GW_TCCLR  = 6'h02;
  localparam logic [5:0] GW_ERMSK  = 6'h03;
  localparam logic [5:0] GW_ERCLR  = 6'h04;
  localparam logic [5:0] GW_TCRAW  = 6'h05;
  localparam logic [5:0] GW_ERRAW  = 6'h06;
  localparam logic [5:0] GW_ENCH   = 6'h07;
  localparam logic [5:0] GW_GCFG   = 6'h0C;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_ERIE_BIT  = 14;
  localparam int CFG_TCIE_BIT  = 15;
  localparam int GCFG_W        = 3;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic two_ch);
    case (idx)
      3'd0:    id_byte = two_ch ? 8'h81 : 8'h80;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h0A;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    word_sel,
  input  logic [DW-1:0] wdata,
  output chan_regs_t    regs_o
);
  chan_regs_t regs_q, regs_nx;
  logic       upd;

  always_comb begin
    regs_nx = regs_q;
    upd     = 1'b0;
    if (wr_en) begin
      upd = 1'b1;
      case (word_sel)
        CW_SRC:  regs_nx.src = wdata;
        CW_DST:  regs_nx.dst = wdata;
        CW_NXT:  regs_nx.nxt = wdata;
        CW_CTL:  regs_nx.ctl = wdata;
        CW_CFG:  regs_nx.cfg = wdata;
        default: upd = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   regs_q <= '0;
    else if (upd) regs_q <= regs_nx;
  end

  assign regs_o = regs_q;

  // R3: without a write strobe the channel words never move
  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  input  logic           tc_clr_we,
  input  logic           er_clr_we,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] tc_ie,
  input  logic [NCH-1:0] er_ie,
  output logic [NCH-1:0] tc_raw_o,
  output logic [NCH-1:0] er_raw_o,
  output logic           irq_o
);
  logic [NCH-1:0] tc_q, tc_nx, er_q, er_nx;
  logic           tc_upd, er_upd;

  always_comb begin
    tc_nx  = tc_q;
    er_nx  = er_q;
    if (tc_clr_we) tc_nx = tc_nx & ~clr_bits;
    if (er_clr_we) er_nx = er_nx & ~clr_bits;
    tc_nx  = tc_nx | tc_set;   // set wins over a same-cycle clear
    er_nx  = er_nx | err_set;
    tc_upd = tc_clr_we | (|tc_set);
    er_upd = er_clr_we | (|err_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tc_q <= '0;
    else if (tc_upd) tc_q <= tc_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      er_q <= '0;
    else if (er_upd) er_q <= er_nx;
  end

  assign tc_raw_o = tc_q;
  assign er_raw_o = er_q;
  assign irq_o    = |((tc_q & tc_ie) | (er_q & er_ie));

  // R4: a set pulse always lands, even against a clear
  a_r4_tc_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));
  a_r4_er_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((er_q & $past(err_set)) == $past(err_set)));
  // R5: cleared bits without a competing set are gone next cycle
  a_r5_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tc_clr_we |=> ((tc_q & $past(clr_bits & ~tc_set)) == '0));
  a_r5_er_clear: assert property (@(posedge clk) disable iff (!rst_n)
    er_clr_we |=> ((er_q & $past(clr_bits & ~err_set)) == '0));
  // R4: raw state holds when nothing touches it
  a_r4_raw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_clr_we && tc_set == '0) |=> $stable(tc_q));
endmodule

// File: rtl/dma_regfile_irq.sv
module dma_regfile_irq
  import dma_rf_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  output logic           ctl_enable,
  output logic [1:0]     ctl_endian,
  output logic [NCH-1:0] ch_enabled,
  output logic           irq
);
  localparam int  PAD    = DW - NCH;
  localparam logic TWO_CH = (NCH == 2);

  logic rst_n_s;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  // address decode
  logic       in_chan, in_glob, in_id;
  logic [2:0] ch_idx, ch_word, id_idx;
  logic [5:0] g_word;
  logic       acc_wr, acc_rd;

  assign in_chan = (bus_addr[11:8] == 4'h1);
  assign in_glob = (bus_addr[11:8] == 4'h0);
  assign in_id   = (bus_addr[11:5] == 7'h7F);
  assign ch_idx  = bus_addr[7:5];
  assign ch_word = bus_addr[4:2];
  assign id_idx  = bus_addr[4:2];
  assign g_word  = bus_addr[7:2];
  assign acc_wr  = bus_sel & bus_wr;
  assign acc_rd  = bus_sel & ~bus_wr;

  // channel banks
  chan_regs_t     cregs [NCH];
  logic [NCH-1:0] tc_ie, er_ie;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic we_c;
    assign we_c = acc_wr & in_chan & (ch_idx == c[2:0]);
    dma_chan_bank u_bank (
      .clk(clk), .rst_n(rst_n_s), .wr_en(we_c), .word_sel(ch_word),
      .wdata(bus_wdata), .regs_o(cregs[c])
    );
    assign tc_ie[c]      = cregs[c].cfg[CFG_TCIE_BIT];
    assign er_ie[c]      = cregs[c].cfg[CFG_ERIE_BIT];
    assign ch_enabled[c] = cregs[c].cfg[CFG_EN_BIT];
  end

  // interrupt state
  logic [NCH-1:0] tc_raw, er_raw;
  logic           tc_clr_we, er_clr_we;

  assign tc_clr_we = acc_wr & in_glob & (g_word == GW_TCCLR);
  assign er_clr_we = acc_wr & in_glob & (g_word == GW_ERCLR);

  dma_irq_ctl #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .tc_set(tc_set), .err_set(err_set),
    .tc_clr_we(tc_clr_we), .er_clr_we(er_clr_we), .clr_bits(bus_wdata[NCH-1:0]),
    .tc_ie(tc_ie), .er_ie(er_ie), .tc_raw_o(tc_raw), .er_raw_o(er_raw), .irq_o(irq)
  );

  // global configuration
  logic [GCFG_W-1:0] gcfg_q, gcfg_nx;
  logic              gcfg_we;

  assign gcfg_we = acc_wr & in_glob & (g_word == GW_GCFG);

  always_comb begin
    gcfg_nx = gcfg_q;
    if (gcfg_we) gcfg_nx = bus_wdata[GCFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     gcfg_q <= '0;
    else if (gcfg_we) gcfg_q <= gcfg_nx;
  end

  assign ctl_enable = gcfg_q[0];
  assign ctl_endian = gcfg_q[2:1];

  // read mux
  chan_regs_t     sel_regs;
  logic [NCH-1:0] tc_msk, er_msk;
  logic [31:0]    rd_nx, rd_q;

  assign tc_msk = tc_raw & tc_ie;
  assign er_msk = er_raw & er_ie;

  always_comb begin
    sel_regs = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_idx == c[2:0]) sel_regs = cregs[c];
  end

  always_comb begin
    rd_nx = '0;
    if (in_chan && int'(ch_idx) < NCH) begin
      case (ch_word)
        CW_SRC:  rd_nx = sel_regs.src;
        CW_DST:  rd_nx = sel_regs.dst;
        CW_NXT:  rd_nx = sel_regs.nxt;
        CW_CTL:  rd_nx = sel_regs.ctl;
        CW_CFG:  rd_nx = sel_regs.cfg;
        default: rd_nx = '0;
      endcase
    end else if (in_glob) begin
      case (g_word)
        GW_STAT:  rd_nx = {{PAD{1'b0}}, tc_msk | er_msk};
        GW_TCMSK: rd_nx = {{PAD{1'b0}}, tc_msk};
        GW_ERMSK: rd_nx = {{PAD{1'b0}}, er_msk};
        GW_TCRAW: rd_nx = {{PAD{1'b0}}, tc_raw};
        GW_ERRAW: rd_nx = {{PAD{1'b0}}, er_raw};
        GW_ENCH:  rd_nx = {{PAD{1'b0}}, ch_enabled};
        GW_GCFG:  rd_nx = {{(DW-GCFG_W){1'b0}}, gcfg_q};
        default:  rd_nx = '0;
      endcase
    end else if (in_id) begin
      rd_nx = {24'h0, id_byte(id_idx, TWO_CH)};
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rd_q <= '0;
    else if (acc_rd) rd_q <= rd_nx;
  end

  assign bus_rdata = rd_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:NCH]};

  // R12: read data only moves on a read access
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !acc_rd |=> $stable(rd_q));
  // R10: configuration only changes on its own write
  a_r10_gcfg_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !gcfg_we |=> $stable(gcfg_q));
endmodule

// File: tb/tb_dma_regfile_irq.sv
`timescale 1ns/1ps
module tb_dma_regfile_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, rdata8, rdata2;
  logic [7:0]  tc_set, err_set;
  logic        en8, en2, irq8, irq2;
  logic [1:0]  end8, end2;
  logic [7:0]  chen8;
  logic [1:0]  chen2;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dma_regfile_irq #(.NCH(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata8),
    .tc_set(tc_set), .err_set(err_set), .ctl_enable(en8), .ctl_endian(end8),
    .ch_enabled(chen8), .irq(irq8)
  );

  dma_regfile_irq #(.NCH(2)) dut_two (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
    .tc_set(tc_set[1:0]), .err_set(err_set[1:0]), .ctl_enable(en2), .ctl_endian(end2),
    .ch_enabled(chen2), .irq(irq2)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d8, output logic [31:0] d2);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d8 = rdata8; d2 = rdata2;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v8, v2;
    rd(a, v8, v2);
    check(tag, v8, exp);
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] e);
    @(negedge clk);
    tc_set = t; err_set = e;
    @(negedge clk);
    tc_set = 0; err_set = 0;
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", rdata8, 0);
    check("R1 irq after reset", {31'b0, irq8}, 0);
    rd_chk("R1 status", 12'h000, 0);
    rd_chk("R1 raw tc", 12'h014, 0);
    rd_chk("R1 gcfg", 12'h030, 0);
    rd_chk("R1 ch3 cfg", 12'h170, 0);
  endtask

  task automatic t_chan_rw();
    int chs [3] = '{0, 3, 7};
    foreach (chs[i]) begin
      for (int w = 0; w < 5; w++)
        wr(12'h100 + 12'(chs[i] * 32 + w * 4), 32'hA5000000 | (chs[i] << 12) | (w << 4) | 32'h2);
    end
    foreach (chs[i]) begin
      for (int w = 0; w < 5; w++)
        rd_chk("R2 channel word", 12'h100 + 12'(chs[i] * 32 + w * 4),
               32'hA5000000 | (chs[i] << 12) | (w << 4) | 32'h2);
    end
  endtask

  task automatic t_ignored();
    logic [31:0] v8, v2;
    wr(12'h114, 32'hDEADBEEF);
    rd_chk("R3 channel word 0x14", 12'h114, 0);
    rd_chk("R3 ch0 src intact", 12'h100, 32'hA5000002);
    wr(12'h020, 32'h12345678);
    rd_chk("R3 undefined global", 12'h020, 0);
    wr(12'h140, 32'hCAFEF00D);
    rd(12'h140, v8, v2);
    check("R3 out-of-range channel reads zero (2ch)", v2, 0);
    check("R3 same window live on 8ch", v8, 32'hCAFEF00D);
    rd(12'h120, v8, v2);
    check("R3 2ch channel1 unaffected", v2, 0);
    wr(12'hFE0, 32'h0);
    rd_chk("R11 id write ignored", 12'hFE0, 32'h80);
  endtask

  task automatic t_raw();
    for (int c = 0; c < 8; c++) wr(12'h110 + 12'(c * 32), 0);
    pulse(8'h05, 8'h30);
    rd_chk("R4 raw tc", 12'h014, 32'h05);
    rd_chk("R4 raw err", 12'h018, 32'h30);
    rd_chk("R6 masked tc with no enables", 12'h004, 0);
    check("R8 irq low with no enables", {31'b0, irq8}, 0);
  endtask

  task automatic t_mask();
    wr(12'h110, 32'h0000_8000);
    rd_chk("R6 masked tc", 12'h004, 32'h01);
    check("R8 irq from tc", {31'b0, irq8}, 1);
    wr(12'h1B0, 32'h0000_4000);
    rd_chk("R6 masked err", 12'h00C, 32'h20);
    rd_chk("R7 combined", 12'h000, 32'h21);
  endtask

  task automatic t_clear();
    wr(12'h008, 32'hFFFF_FF01);
    rd_chk("R5 tc clear", 12'h014, 32'h04);
    rd_chk("R5 clear reg reads zero", 12'h008, 0);
    rd_chk("R7 combined after tc clear", 12'h000, 32'h20);
    check("R8 irq still high from err", {31'b0, irq8}, 1);
    wr(12'h010, 32'h0000_00FF);
    rd_chk("R5 err clear", 12'h018, 0);
    check("R8 irq low after clears", {31'b0, irq8}, 0);
  endtask

  task automatic t_race();
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h008; bus_wdata = 32'h02; tc_set = 8'h02;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tc_set = 0;
    rd_chk("R4 set wins over clear", 12'h014, 32'h06);
    wr(12'h008, 32'h06);
    rd_chk("R5 later clear", 12'h014, 0);
  endtask

  task automatic t_enabled();
    wr(12'h150, 32'h1);
    wr(12'h1D0, 32'h1);
    rd_chk("R9 enabled bitmap read", 12'h01C, 32'h44);
    check("R9 ch_enabled port", {24'b0, chen8}, 32'h44);
  endtask

  task automatic t_gcfg();
    wr(12'h030, 32'hFFFF_FFFF);
    rd_chk("R10 gcfg upper bits zero", 12'h030, 32'h7);
    check("R10 ctl_enable", {31'b0, en8}, 1);
    check("R10 ctl_endian", {30'b0, end8}, 3);
    wr(12'h030, 32'h2);
    rd_chk("R10 gcfg", 12'h030, 32'h2);
    check("R10 ctl_enable off", {31'b0, en8}, 0);
  endtask

  task automatic t_id();
    logic [7:0] exp8 [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [31:0] v8, v2;
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), v8, v2);
      check("R11 id byte 8ch", v8, {24'b0, exp8[i]});
      check("R11 id byte 2ch", v2, {24'b0, (i == 0) ? 8'h81 : exp8[i]});
    end
  endtask

  task automatic t_latency();
    wr(12'h104, 32'h1357_9BDF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'h104;
    check("R12 old data before edge", rdata8, 32'hB1);
    @(negedge clk);
    bus_sel = 0;
    check("R12 data one cycle later", rdata8, 32'h1357_9BDF);
    wr(12'h104, 32'h0);
    repeat (3) @(negedge clk);
    check("R12 rdata held", rdata8, 32'h1357_9BDF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    tc_set = 0; err_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_chan_rw();
    t_ignored();
    t_raw();
    t_mask();
    t_clear();
    t_race();
    t_enabled();
    t_gcfg();
    t_id();
    t_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule